// File: doc/BRIEF.md
# 8-bit Execute Unit with Six-Flag Status Word

This block is the execute stage of a small 8-bit microcontroller with a 32-entry register file. It takes the 16-bit instruction word and decodes it directly. From the decoded fields it drives the two register-read selects. The register file, which sits outside the block, returns the two operand values in the same cycle.

The block then computes the result of an add, add-with-carry, subtract, compare, AND or OR with an 8-bit immediate, load-immediate, increment or arithmetic shift right by one. It also updates the six status flags from the incoming status word.

Result, write-enable, write address and the new status word appear on registered outputs one clock after the instruction is presented. Clearing a set of bits is done by AND with the complemented mask, so it needs no encoding of its own. A compare computes the difference and its flags but never raises the write-enable.

Top module: `alu8_exec`

## Requirements
- R1: Register-register add `000011 r ddddd rrrr` drives `dst_sel` = bits 8..4 and `src_sel` = {bit 9, bits 3..0}, and writes dst+src. Add-with-carry `000111 r ddddd rrrr` writes dst+src+C.
- R2: Subtract `000110 r ddddd rrrr` writes dst−src. Compare `000101 r ddddd rrrr` computes the same difference and flags, and holds `wr_en` low.
- R3: AND-immediate `0111 KKKK dddd KKKK` and OR-immediate `0110 KKKK dddd KKKK` use K = {bits 11..8, bits 3..0} and destination 16+dddd. Clearing mask M is AND-immediate with K = ~M.
- R4: Load-immediate `1110 KKKK dddd KKKK` writes K to register 16+dddd and passes the status word through unchanged.
- R5: Increment `1001010 ddddd 0011` writes dst+1. Arithmetic shift right `1001010 ddddd 0101` writes {dst[7], dst[7:1]}.
- R6: Status bit positions are fixed: 5 half carry H, 4 sign S, 3 overflow V, 2 negative N, 1 zero Z, 0 carry C.
- R7: For every flag-updating operation, N is result bit 7, Z is set exactly when the 8-bit result is zero, and S = N xor V.
- R8: For add and add-with-carry, C is the carry out of bit 7 and H the carry out of bit 3. For subtract and compare, C is set when src > dst unsigned and H when src[3:0] > dst[3:0].
- R9: V is set when the signed result of add, subtract, compare or increment falls outside −128..127. For shift right, V = N xor C, where C is the bit shifted out of bit 0.
- R10: AND-immediate and OR-immediate clear V. These two and increment keep C and H from the incoming status word.
- R11: Any other instruction word holds `wr_en` low and passes the incoming status word through unchanged.
- R12: Outputs change one clock after the inputs are sampled. Synchronous reset drives result, `wr_en`, `wr_addr` and `sreg_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word to execute |
| rd_val | input | 8 | Value of the register selected by `dst_sel` |
| rr_val | input | 8 | Value of the register selected by `src_sel` |
| sreg_in | input | 6 | Current status word |
| dst_sel | output | 5 | Destination/first-operand register select (combinational) |
| src_sel | output | 5 | Second-operand register select (combinational) |
| result | output | 8 | Registered result |
| wr_en | output | 1 | Registered destination write-enable |
| wr_addr | output | 5 | Registered destination register index |
| sreg_out | output | 6 | Registered updated status word |

## Verification
The datapath carries no state from one instruction to the next. A wrong decode, a wrong carry chain or a wrong flag mux therefore shows on `result`, `wr_en` or `sreg_out` one clock after the offending instruction, and never later. The add sweep covers all 65,536 operand pairs, and the other operations sweep densely, so a flag bit tapped at the wrong position or a borrow taken from the wrong polarity is caught within the first few vectors that exercise it. Compare and unknown words are checked at the ports: `wr_en` must be low, and `sreg_out` must equal an incoming status word chosen to differ from what any real update would produce.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_ADC, OP_SUB, OP_CP,
    OP_ANDI, OP_ORI, OP_LDI, OP_INC, OP_ASR
  } op_e;

  localparam int FL_H = 5;
  localparam int FL_S = 4;
  localparam int FL_V = 3;
  localparam int FL_N = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
#(
  parameter int IW = 16,
  parameter int RW = 5,
  parameter int DW = 8
) (
  input  logic [IW-1:0] ins,
  output op_e           op,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] src,
  output logic [DW-1:0] imm
);
  always_comb begin
    op  = OP_NOP;
    dst = ins[8:4];
    src = {ins[9], ins[3:0]};
    imm = {ins[11:8], ins[3:0]};
    casez (ins)
      16'b0000_11??_????_????: op = OP_ADD;
      16'b0001_11??_????_????: op = OP_ADC;
      16'b0001_10??_????_????: op = OP_SUB;
      16'b0001_01??_????_????: op = OP_CP;
      16'b0111_????_????_????: op = OP_ANDI;
      16'b0110_????_????_????: op = OP_ORI;
      16'b1110_????_????_????: op = OP_LDI;
      16'b1001_010?_????_0011: op = OP_INC;
      16'b1001_010?_????_0101: op = OP_ASR;
      default:                 op = OP_NOP;
    endcase
    if (op == OP_ANDI || op == OP_ORI || op == OP_LDI)
      dst = {1'b1, ins[7:4]};
  end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          c,
  output logic          h,
  output logic          v
);
  logic [DW-1:0] be;
  logic          ci;
  logic [DW:0]   full;
  logic [4:0]    low;

  assign be   = sub ? ~b : b;
  assign ci   = sub ? 1'b1 : cin;
  assign full = {1'b0, a} + {1'b0, be} + {{DW{1'b0}}, ci};
  assign low  = {1'b0, a[3:0]} + {1'b0, be[3:0]} + {4'b0000, ci};
  assign r    = full[DW-1:0];
  assign c    = full[DW] ^ sub;
  assign h    = low[4] ^ sub;
  assign v    = (a[DW-1] == be[DW-1]) && (r[DW-1] != a[DW-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r,
  output logic          c
);
  always_comb begin
    c = a[0];
    case (op)
      OP_ANDI: r = a & b;
      OP_ORI:  r = a | b;
      OP_ASR:  r = {a[DW-1], a[DW-1:1]};
      default: r = b;
    endcase
  end
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int IW = 16,
  parameter int DW = 8,
  parameter int RW = 5,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] rr_val,
  input  logic [FW-1:0] sreg_in,
  output logic [RW-1:0] dst_sel,
  output logic [RW-1:0] src_sel,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [RW-1:0] wr_addr,
  output logic [FW-1:0] sreg_out
);
  op_e           op;
  logic [DW-1:0] imm, opb, add_b;
  logic [DW-1:0] as_r, lg_r, n_res;
  logic          as_c, as_h, as_v, lg_c, add_ci, add_sub;
  logic          n_we;
  logic [FW-1:0] n_fl;

  alu8_decode #(.IW(IW), .RW(RW), .DW(DW)) u_dec (
    .ins(instr), .op(op), .dst(dst_sel), .src(src_sel), .imm(imm)
  );

  assign opb     = (op == OP_ANDI || op == OP_ORI || op == OP_LDI) ? imm : rr_val;
  assign add_b   = (op == OP_INC) ? '0 : rr_val;
  assign add_ci  = (op == OP_INC) ? 1'b1 : ((op == OP_ADC) ? sreg_in[FL_C] : 1'b0);
  assign add_sub = (op == OP_SUB) || (op == OP_CP);

  alu8_addsub #(.DW(DW)) u_as (
    .a(rd_val), .b(add_b), .cin(add_ci), .sub(add_sub),
    .r(as_r), .c(as_c), .h(as_h), .v(as_v)
  );

  alu8_logic #(.DW(DW)) u_lg (
    .op(op), .a(rd_val), .b(opb), .r(lg_r), .c(lg_c)
  );

  always_comb begin
    n_res = '0;
    n_we  = 1'b0;
    n_fl  = sreg_in;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_CP, OP_INC: begin
        n_res      = as_r;
        n_we       = (op != OP_CP);
        n_fl[FL_V] = as_v;
        if (op != OP_INC) begin
          n_fl[FL_C] = as_c;
          n_fl[FL_H] = as_h;
        end
      end
      OP_ANDI, OP_ORI: begin
        n_res      = lg_r;
        n_we       = 1'b1;
        n_fl[FL_V] = 1'b0;
      end
      OP_ASR: begin
        n_res      = lg_r;
        n_we       = 1'b1;
        n_fl[FL_C] = lg_c;
        n_fl[FL_V] = lg_r[DW-1] ^ lg_c;
      end
      OP_LDI: begin
        n_res = lg_r;
        n_we  = 1'b1;
      end
      default: ;
    endcase
    if (op != OP_NOP && op != OP_LDI) begin
      n_fl[FL_N] = n_res[DW-1];
      n_fl[FL_Z] = (n_res == '0);
      n_fl[FL_S] = n_res[DW-1] ^ n_fl[FL_V];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      sreg_out <= '0;
    end else begin
      result   <= n_res;
      wr_en    <= n_we;
      wr_addr  <= dst_sel;
      sreg_out <= n_fl;
    end
  end
endmodule

// File: rtl/alu8_exec_chk.sv
module alu8_exec_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input op_e        op,
  input logic [7:0] imm,
  input logic [5:0] sreg_in,
  input logic [7:0] result,
  input logic       wr_en,
  input logic [5:0] sreg_out
);
  // R7
  sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_NOP && op != OP_LDI) |=>
      (sreg_out[FL_S] == (sreg_out[FL_N] ^ sreg_out[FL_V])));

  // R7
  zero_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_NOP && op != OP_LDI) |=> (sreg_out[FL_Z] == (result == 8'h00)));

  // R2
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CP) |=> !wr_en);

  // R11
  unknown_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP) |=> (!wr_en && sreg_out == $past(sreg_in)));

  // R4
  ldi_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LDI) |=> (wr_en && result == $past(imm) && sreg_out == $past(sreg_in)));

  // R10
  logic_v_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ANDI || op == OP_ORI) |=>
      (!sreg_out[FL_V] && sreg_out[FL_C] == $past(sreg_in[FL_C])
       && sreg_out[FL_H] == $past(sreg_in[FL_H])));
endmodule

bind alu8_exec alu8_exec_chk u_chk (
  .clk(clk), .rst(rst), .op(op), .imm(imm), .sreg_in(sreg_in),
  .result(result), .wr_en(wr_en), .sreg_out(sreg_out)
);

// File: tb/alu8_exec_test.sv
`timescale 1ns/1ps
module alu8_exec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [7:0]  rd_val = 8'h00, rr_val = 8'h00;
  logic [5:0]  sreg_in = 6'h00;
  logic [4:0]  dst_sel, src_sel, wr_addr;
  logic [7:0]  result;
  logic        wr_en;
  logic [5:0]  sreg_out;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  alu8_exec uut (
    .clk(clk), .rst(rst), .instr(instr), .rd_val(rd_val), .rr_val(rr_val),
    .sreg_in(sreg_in), .dst_sel(dst_sel), .src_sel(src_sel), .result(result),
    .wr_en(wr_en), .wr_addr(wr_addr), .sreg_out(sreg_out)
  );

  function automatic int sgn(input logic [7:0] x);
    return (x >= 8'd128) ? int'(x) - 256 : int'(x);
  endfunction

  // returns {wr_addr, wr_en, result, sreg}
  function automatic logic [19:0] model(input logic [15:0] w, input logic [7:0] a,
                                        input logic [7:0] b, input logic [5:0] s);
    logic [5:0] f = s;
    logic [7:0] r = 8'h00;
    logic       we = 1'b0;
    logic       upd = 1'b1;
    logic [4:0] da = w[8:4];
    logic [7:0] k = {w[11:8], w[3:0]};
    int t;
    int ci = s[0] ? 1 : 0;
    if (w[15:10] == 6'b000011 || w[15:10] == 6'b000111) begin
      if (w[15:10] == 6'b000011) ci = 0;
      t = int'(a) + int'(b) + ci;
      r = t[7:0]; we = 1'b1;
      f[0] = (t > 255);
      f[5] = (int'(a & 8'h0F) + int'(b & 8'h0F) + ci) > 15;
      t = sgn(a) + sgn(b) + ci;
      f[3] = (t > 127) || (t < -128);
    end else if (w[15:10] == 6'b000110 || w[15:10] == 6'b000101) begin
      r = a - b; we = (w[15:10] == 6'b000110);
      f[0] = (b > a);
      f[5] = (b[3:0] > a[3:0]);
      t = sgn(a) - sgn(b);
      f[3] = (t > 127) || (t < -128);
    end else if (w[15:12] == 4'b0111 || w[15:12] == 4'b0110) begin
      r = (w[12]) ? (a & k) : (a | k); we = 1'b1; da = {1'b1, w[7:4]};
      f[3] = 1'b0;
    end else if (w[15:12] == 4'b1110) begin
      r = k; we = 1'b1; da = {1'b1, w[7:4]}; upd = 1'b0;
    end else if (w[15:9] == 7'b1001010 && w[3:0] == 4'b0011) begin
      r = a + 8'd1; we = 1'b1;
      f[3] = (a == 8'd127);
    end else if (w[15:9] == 7'b1001010 && w[3:0] == 4'b0101) begin
      r = {a[7], a[7:1]}; we = 1'b1;
      f[0] = a[0];
      f[3] = r[7] ^ a[0];
    end else begin
      upd = 1'b0;
    end
    if (upd) begin
      f[2] = r[7];
      f[1] = (r == 8'h00);
      f[4] = f[2] ^ f[3];
    end
    return {da, we, r, f};
  endfunction

  task automatic run(input logic [15:0] w, input logic [7:0] a, input logic [7:0] b,
                     input logic [5:0] s, input string tag);
    logic [19:0] exp;
    logic [19:0] got;
    @(negedge clk);
    instr = w; rd_val = a; rr_val = b; sreg_in = s;
    exp = model(w, a, b, s);
    @(posedge clk);
    #1;
    got = {wr_addr, wr_en, result, sreg_out};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%h a=%h b=%h s=%b: got addr=%0d we=%b res=%h sreg=%b expected addr=%0d we=%b res=%h sreg=%b",
               tag, w, a, b, s, got[19:15], got[14], got[13:6], got[5:0],
               exp[19:15], exp[14], exp[13:6], exp[5:0]);
    end
  endtask

  task automatic check_sel(input logic [15:0] w, input logic [4:0] ed, input logic [4:0] es,
                           input string tag);
    @(negedge clk);
    instr = w;
    #1;
    checks++;
    if (dst_sel !== ed || src_sel !== es) begin
      errors++;
      $display("FAIL %s instr=%h: got dst=%0d src=%0d expected dst=%0d src=%0d",
               tag, w, dst_sel, src_sel, ed, es);
    end
  endtask

  task automatic check_reset(input string tag);
    checks++;
    if (result !== 8'h00 || wr_en !== 1'b0 || wr_addr !== 5'd0 || sreg_out !== 6'd0) begin
      errors++;
      $display("FAIL %s reset: got res=%h we=%b addr=%0d sreg=%b expected all zero",
               tag, result, wr_en, wr_addr, sreg_out);
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: got running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset("R12");
    @(negedge clk);
    rst = 1'b0;

    // R1 register selects: dst = bits 8..4, src = {bit 9, bits 3..0}
    check_sel(16'h0C00 | 16'h0200 | (16'd21 << 4) | 16'd6, 5'd21, 5'd22, "R1");
    check_sel(16'h0C0F | (16'd3 << 4), 5'd3, 5'd15, "R1");
    // R3 immediate destination is 16 + dddd
    check_sel(16'h7A5C, 5'd21, 5'd28, "R3");

    // R1 R6 R7 R8 R9 add, full sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run(16'h0C00 | 16'(((a & 31) << 4) | (b & 15) | ((b & 16) << 5)),
            8'(a), 8'(b), 6'((a ^ b) & 63), "R1 add");

    // R1 R8 add with carry, both carry-in values
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 5)
        for (int c = 0; c < 2; c++)
          run(16'h1C00 | 16'(((b & 31) << 4) | (a & 15)), 8'(a), 8'(b),
              6'(((a + b) & 62) | c), "R1 adc");

    // R2 R8 R9 subtract and compare
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 3) begin
        run(16'h1800 | 16'(((a & 31) << 4) | (b & 15)), 8'(a), 8'(b),
            6'((a * 3 + b) & 63), "R2 sub");
        run(16'h1400 | 16'(((b & 31) << 4) | (a & 15)), 8'(a), 8'(b),
            6'((a + b * 5) & 63), "R2 cp");
      end

    // R3 R10 and/or immediate, R4 load immediate, R5 inc and asr
    for (int a = 0; a < 256; a++) begin
      int k = (a * 37 + 11) & 255;
      logic [15:0] kf = 16'(((k & 240) << 4) | (k & 15) | ((a & 15) << 4));
      run(16'h7000 | kf, 8'(a), 8'h00, 6'(a & 63), "R3 andi");
      run(16'h6000 | kf, 8'(a), 8'h00, 6'((a >> 2) & 63), "R3 ori");
      run(16'hE000 | kf, 8'(a), 8'h00, 6'((a * 7) & 63), "R4 ldi");
      run(16'h9403 | 16'((a & 31) << 4), 8'(a), 8'h00, 6'((a * 5) & 63), "R5 inc");
      run(16'h9405 | 16'((a & 31) << 4), 8'(a), 8'h00, 6'((a * 11) & 63), "R5 asr");
    end

    // R3 clearing mask 0xAA from 0xFF is AND with 0x55
    run(16'h7505, 8'hFF, 8'h00, 6'h3F, "R3 clear-mask");
    // R9 boundaries: 0x7F+1 overflows, 0x80-0x01 overflows, asr of 0x01
    run(16'h9403, 8'h7F, 8'h00, 6'h00, "R9 inc");
    run(16'h1800, 8'h80, 8'h01, 6'h00, "R9 sub");
    run(16'h9405, 8'h01, 8'h00, 6'h00, "R9 asr");

    // R11 unrecognised words pass the status word through
    run(16'h0000, 8'h12, 8'h34, 6'h2A, "R11");
    run(16'hFFFF, 8'h00, 8'h00, 6'h15, "R11");
    run(16'h9408, 8'h80, 8'h00, 6'h3C, "R11");
    run(16'h0400, 8'h05, 8'h05, 6'h01, "R11");
    run(16'h2C00, 8'hFF, 8'hFF, 6'h3F, "R11");

    // R12 reset clears the registered outputs again
    @(negedge clk);
    instr = 16'h0C01; rd_val = 8'h40; rr_val = 8'h40; sreg_in = 6'h3F;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_reset("R12");
    @(negedge clk);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule